// File: doc/BRIEF.md
# Multi-Level QoS Bus Arbiter

This block decides which of eight hosts may use a single shared client port. Each host has a 2-bit programmed priority and a latency-QoS enable flag, both held in one 32-bit configuration register. When its enable flag is set, a host may request a lower level on its own 2-bit QoS input. The programmed value acts as a ceiling on that request.

Every requesting host gets an effective priority between 0 and 3. All requesters at the same level form a pool, and the highest non-empty pool wins. The rule inside a pool depends on the level. Levels 0 and 3 rotate round-robin, and each of the two has its own last-granted pointer. Levels 1 and 2 use fixed ordering, where the lowest host index wins. The registered one-hot grant stays on a host for as long as that host keeps requesting. The effective priority of the winner is sent on to the client together with the grant.

Writes to the configuration register are blocked while a write-lock input is high. The register contents can always be read back.

Top module: `qarb_top`

## Requirements
- R1: After reset the configuration register reads 0. A write with `cfg_we` high and `wr_lock` low is visible on `cfg_rdata` one cycle later.
- R2: A write attempted while `wr_lock` is high leaves `cfg_rdata` unchanged.
- R3: Host i's programmed priority is `cfg[4i+1:4i]`. Its QoS enable is `cfg[4i+2]`. With the enable at 0, its effective priority is the programmed value.
- R4: With the enable at 1, the effective priority is the smaller of `qos_in[2i+1:2i]` and the programmed value.
- R5: When a grant is made, it goes to a host in the highest level that has a request. `gnt_prio` then carries that level.
- R6: In levels 1 and 2, the requesting host with the lowest index wins.
- R7: Levels 0 and 3 each keep their own pointer to the last host granted at that level. The search starts at the next index and wraps around. A pointer moves only when its own level grants.
- R8: `gnt` is registered and at most one bit is set. It stays on a host while that host's `req` stays high. Re-arbitration happens at the first clock edge that samples that `req` low.
- R9: With no requests at an arbitration edge, `gnt` and `gnt_prio` become 0.
- R10: After reset `gnt` and `gnt_prio` are 0, and both round-robin levels start their search at host 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| wr_lock | input | 1 | Write protect; blocks writes when high |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration register contents |
| req | input | 8 | Per-host request |
| qos_in | input | 16 | Per-host 2-bit QoS level, host i at [2i+1:2i] |
| gnt | output | 8 | Registered one-hot grant |
| gnt_prio | output | 2 | Effective priority of the granted host |

## Verification
The bench compares the design against a behavioural model on every clock. It targets these cases and the failure each one would expose:

- **Round-robin wrap-around.** Wrong pointer arithmetic would regrant the same host or skip a neighbour.
- **Level-0 and level-3 pointers sharing state.** One pool's history would then disturb the other's order.
- **QoS requests above the ceiling.** A missing clamp would let a host outrank its programmed level.
- **Grant-hold release.** A design that re-arbitrates while the owner still requests would steal the bus. One that holds too long would stall the other hosts.
- **Locked writes and empty request cycles.** A lock that leaks would corrupt the configuration. A grant that lingers with no requests would point the client at an idle host.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
   localparam int PRIO_W  = 2;
   localparam int FIELD_W = 4;
   localparam int N_LVL   = 1 << PRIO_W;
   typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/qarb_cfg.sv
module qarb_cfg #(
   parameter int N_HOSTS = 8,
   localparam int CFG_W = N_HOSTS * qarb_pkg::FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             lock,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (we && !lock)
         cfg_q <= wdata;
   end

   // R2
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(cfg_q));
endmodule

// File: rtl/qarb_eff.sv
module qarb_eff
   import qarb_pkg::*;
#(
   parameter int N_HOSTS = 8,
   localparam int CFG_W = N_HOSTS * FIELD_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CFG_W-1:0]           cfg,
   input  logic [N_HOSTS*PRIO_W-1:0]  qos,
   output logic [N_HOSTS*PRIO_W-1:0]  eff
);
   for (genvar i = 0; i < N_HOSTS; i++) begin : g_host
      prio_t prog, lim, e;
      logic  en;
      assign prog = cfg[i*FIELD_W +: PRIO_W];
      assign en   = cfg[i*FIELD_W + PRIO_W];
      assign lim  = qos[i*PRIO_W +: PRIO_W];
      assign e    = (en && (lim < prog)) ? lim : prog;
      assign eff[i*PRIO_W +: PRIO_W] = e;

      // R4
      eff_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
         eff[i*PRIO_W +: PRIO_W] <= cfg[i*FIELD_W +: PRIO_W]);
      // R3
      eff_noqos_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg[i*FIELD_W + PRIO_W] |-> eff[i*PRIO_W +: PRIO_W] == cfg[i*FIELD_W +: PRIO_W]);
   end
endmodule

// File: rtl/qarb_rr.sv
module qarb_rr #(
   parameter int N_HOSTS = 8,
   localparam int PW = $clog2(N_HOSTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_HOSTS-1:0] mask,
   input  logic               upd,
   output logic [N_HOSTS-1:0] pick_oh
);
   logic [PW-1:0] ptr_q, pick_idx;
   logic          found;
   int            idx;

   always_comb begin
      pick_oh  = '0;
      pick_idx = '0;
      found    = 1'b0;
      idx      = 0;
      for (int k = 1; k <= N_HOSTS; k++) begin
         idx = (int'(ptr_q) + k) % N_HOSTS;
         if (!found && mask[idx]) begin
            found        = 1'b1;
            pick_oh[idx] = 1'b1;
            pick_idx     = PW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= PW'(N_HOSTS - 1);
      else if (upd)
         ptr_q <= pick_idx;
   end

   // R7
   rr_pick_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask != '0) |-> ($onehot(pick_oh) && ((pick_oh & ~mask) == '0)));
   // R7
   rr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(ptr_q));
endmodule

// File: rtl/qarb_fixed.sv
module qarb_fixed #(
   parameter int N_HOSTS = 8
) (
   input  logic [N_HOSTS-1:0] mask,
   output logic [N_HOSTS-1:0] pick_oh
);
   always_comb begin
      pick_oh = '0;
      for (int i = N_HOSTS - 1; i >= 0; i--) begin
         if (mask[i]) pick_oh = N_HOSTS'(1) << i;
      end
   end

   // R6
   fixed_lowest_chk: assert final ((mask == '0) || (pick_oh == (mask & (~mask + 1'b1))));
endmodule

// File: rtl/qarb_top.sv
module qarb_top
   import qarb_pkg::*;
#(
   parameter int N_HOSTS = 8,
   localparam int CFG_W = N_HOSTS * FIELD_W,
   localparam int QOS_W = N_HOSTS * PRIO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               wr_lock,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic [CFG_W-1:0]   cfg_rdata,
   input  logic [N_HOSTS-1:0] req,
   input  logic [QOS_W-1:0]   qos_in,
   output logic [N_HOSTS-1:0] gnt,
   output logic [PRIO_W-1:0]  gnt_prio
);
   if (N_HOSTS < 2 || N_HOSTS > 32) begin : g_bad_hosts
      $error("qarb_top: N_HOSTS must be within 2..32");
   end

   logic [CFG_W-1:0]   cfg_q;
   logic [QOS_W-1:0]   eff;
   logic [N_HOSTS-1:0] lvl_mask [N_LVL];
   logic [N_HOSTS-1:0] lvl_pick [N_LVL];
   logic [N_LVL-1:0]   lvl_any;
   logic [N_HOSTS-1:0] win_oh, gnt_q;
   prio_t              win_lvl, prio_q;
   logic               hold, fire;

   qarb_cfg #(.N_HOSTS(N_HOSTS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .lock(wr_lock),
      .wdata(cfg_wdata), .cfg_q(cfg_q));

   qarb_eff #(.N_HOSTS(N_HOSTS)) u_eff (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .qos(qos_in), .eff(eff));

   assign hold = |(gnt_q & req);
   assign fire = !hold && (req != '0);

   for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
      for (genvar i = 0; i < N_HOSTS; i++) begin : g_m
         assign lvl_mask[l][i] = req[i] && (eff[i*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
      assign lvl_any[l] = |lvl_mask[l];
      if (l == 0 || l == N_LVL - 1) begin : g_rr
         qarb_rr #(.N_HOSTS(N_HOSTS)) u_pick (
            .clk(clk), .rst_n(rst_n), .mask(lvl_mask[l]),
            .upd(fire && (win_lvl == PRIO_W'(l))), .pick_oh(lvl_pick[l]));
      end else begin : g_fix
         qarb_fixed #(.N_HOSTS(N_HOSTS)) u_pick (
            .mask(lvl_mask[l]), .pick_oh(lvl_pick[l]));
      end
   end

   always_comb begin
      win_lvl = '0;
      win_oh  = '0;
      for (int l = 0; l < N_LVL; l++) begin
         if (lvl_any[l]) begin
            win_lvl = PRIO_W'(l);
            win_oh  = lvl_pick[l];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_q  <= '0;
         prio_q <= '0;
      end else if (!hold) begin
         gnt_q  <= win_oh;
         prio_q <= win_lvl;
      end
   end

   assign gnt       = gnt_q;
   assign gnt_prio  = prio_q;
   assign cfg_rdata = cfg_q;

   // R8
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
   // R8
   gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && (gnt & req) != '0) |=> $stable(gnt) && $stable(gnt_prio));
   // R9
   idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (gnt == '0 && gnt_prio == '0));
   // R5
   gnt_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0 && (gnt & req) == '0) |=> (gnt != '0 && (gnt & $past(req)) == gnt));
endmodule

// File: tb/qarb_top_tb.sv
`timescale 1ns/1ps
module qarb_top_tb;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        wr_lock = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [7:0]  req = '0;
   logic [15:0] qos_in = '0;
   logic [7:0]  gnt;
   logic [1:0]  gnt_prio;

   int total = 0;
   int bad = 0;
   logic [31:0] m_cfg;
   int m_gnt;
   int m_prio;
   int m_ptr [4];
   string tag;

   always #2.5 clk = ~clk;

   qarb_top u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .wr_lock(wr_lock),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
      .qos_in(qos_in), .gnt(gnt), .gnt_prio(gnt_prio));

   task automatic model_reset();
      m_cfg = '0; m_gnt = -1; m_prio = 0;
      for (int l = 0; l < 4; l++) m_ptr[l] = N - 1;
   endtask

   function automatic int eff_of(int i);
      int p, q;
      p = int'(m_cfg[4*i +: 2]);
      q = int'(qos_in[2*i +: 2]);
      if (m_cfg[4*i+2] && q < p) return q;
      return p;
   endfunction

   task automatic model_step();
      int top, win;
      if (!(m_gnt >= 0 && req[m_gnt])) begin
         top = -1; win = -1;
         for (int i = 0; i < N; i++)
            if (req[i] && eff_of(i) > top) top = eff_of(i);
         if (top < 0) begin
            m_gnt = -1; m_prio = 0;
         end else begin
            if (top == 1 || top == 2) begin
               for (int i = N - 1; i >= 0; i--)
                  if (req[i] && eff_of(i) == top) win = i;
            end else begin
               for (int k = N; k >= 1; k--)
                  if (req[(m_ptr[top] + k) % N] && eff_of((m_ptr[top] + k) % N) == top)
                     win = (m_ptr[top] + k) % N;
               m_ptr[top] = win;
            end
            m_gnt = win; m_prio = top;
         end
      end
      if (cfg_we && !wr_lock) m_cfg = cfg_wdata;
   endtask

   task automatic compare();
      logic [7:0] eg;
      eg = (m_gnt < 0) ? 8'h00 : (8'h01 << m_gnt);
      total++;
      if (gnt !== eg || gnt_prio !== 2'(m_prio) || cfg_rdata !== m_cfg) begin
         bad++;
         $display("FAIL %s: gnt=%h prio=%0d cfg=%h expected gnt=%h prio=%0d cfg=%h",
                  tag, gnt, gnt_prio, cfg_rdata, eg, m_prio, m_cfg);
      end
   endtask

   task automatic step();
      if (rst_n) model_step(); else model_reset();
      @(posedge clk);
      @(negedge clk);
      compare();
      cfg_we = 1'b0;
   endtask

   task automatic write_cfg(input logic [31:0] v, input logic lk);
      cfg_we = 1'b1; wr_lock = lk; cfg_wdata = v;
      step();
      wr_lock = 1'b0;
   endtask

   task automatic rand_phase(input int n, input int drop_pct, input logic rand_qos);
      for (int c = 0; c < n; c++) begin
         if (m_gnt < 0 || int'($urandom_range(99)) < drop_pct) req = 8'($urandom);
         if (rand_qos) qos_in = 16'($urandom);
         step();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk);
      tag = "R10 reset"; step(); step();
      rst_n = 1'b1;
      tag = "R1 reset value"; step();
      tag = "R1 write"; write_cfg(32'h3210_3210, 1'b0); step();
      tag = "R2 locked write"; write_cfg(32'hFFFF_FFFF, 1'b1); step();
      tag = "R2 locked write again"; write_cfg(32'h0000_0000, 1'b1); step();
      // R10 / R7: all level 0, every host requesting, release owner each cycle
      tag = "R10 rr start"; write_cfg(32'h0, 1'b0);
      req = 8'hFF; step();
      tag = "R7 rr level0 rotate";
      for (int c = 0; c < 20; c++) begin
         if (m_gnt >= 0) req = 8'hFF & ~(8'h01 << m_gnt);
         step(); req = 8'hFF;
      end
      tag = "R8 hold"; req = 8'hFF; rand_phase(10, 0, 1'b0);
      tag = "R9 idle"; req = 8'h00; step(); step();
      // R7: level 3 pool has its own pointer
      tag = "R7 rr level3"; write_cfg(32'h3300_3300, 1'b0);
      rand_phase(300, 60, 1'b0);
      // R6: fixed levels
      tag = "R6 fixed"; write_cfg(32'h1212_2121, 1'b0);
      rand_phase(300, 60, 1'b0);
      // R3 / R5: mixed programmed levels, no QoS
      tag = "R3 R5 mixed"; write_cfg(32'h3210_0123, 1'b0);
      rand_phase(400, 50, 1'b1);
      // R4: QoS enabled on every host, clamped by ceiling
      tag = "R4 qos clamp"; write_cfg(32'h7654_7567, 1'b0);
      rand_phase(600, 50, 1'b1);
      tag = "R4 qos all3"; write_cfg(32'h7777_6655, 1'b0);
      rand_phase(600, 70, 1'b1);
      // R1 / R2 mixed with traffic
      tag = "R1 R2 writes under traffic";
      for (int c = 0; c < 200; c++) begin
         cfg_we = 1'b1; wr_lock = 1'($urandom); cfg_wdata = $urandom;
         if (m_gnt < 0 || $urandom_range(1) == 0) req = 8'($urandom);
         qos_in = 16'($urandom);
         step();
         wr_lock = 1'b0;
      end
      tag = "R8 random"; rand_phase(2000, 40, 1'b1);
      tag = "R9 idle end"; req = 8'h00; step(); step();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule